// File: doc/BRIEF.md
# Distributed Priority Bus Arbitration Controller

Several devices share a synchronous bus, and no central arbiter decides who owns it. Each device has its own small clocked controller. The controller knows the device's fixed priority and sees the request lines of every device. When the device asks for the bus, its controller drives the device's own request line. In each cycle the controller decides, on its own, whether it takes the bus at the next clock edge. It takes the bus only if no device of higher priority is driving its request line in that cycle.

A transaction always lasts exactly one cycle. After a device has held the bus, its controller spends one forced cycle off the bus. During that cycle the request line stays low, so the next requester in priority order can win. The same device can therefore never be master in two cycles in a row. The wrapper puts four controllers on one shared set of request lines. Bit i of each vector belongs to the device of priority i+1, so bit 3 has the highest priority and bit 0 the lowest. If higher-priority devices keep requesting, a low-priority device can be kept off the bus indefinitely.

Top module: `dist_bus_arb`

## Requirements
- R1: While reset is asserted, and right after it is released, every bit of `br_o`, `master_o` and `done_o` is 0.
- R2: If an idle controller sees its `req_i` bit high at a clock edge, its `br_o` bit is 1 from the next cycle on. If no higher bit of `br_o` is 1 in that cycle, its `master_o` bit is 1 in the cycle after that.
- R3: At a clock edge, a controller that is driving `br_o` becomes master only if no higher-indexed bit of `br_o` is 1 in that cycle. Of several requesters, only the highest-indexed one wins at that edge.
- R4: Mastership lasts exactly one cycle. The device's `done_o` bit is 1 in the cycle that follows and 0 at all other times.
- R5: No `master_o` bit is 1 in two consecutive cycles. A device whose `req_i` stays high is master at most once in every three cycles.
- R6: Once a `br_o` bit is 1, it stays 1 until the cycle in which that device's `master_o` bit becomes 1, even if `req_i` drops in between. A `br_o` bit is 0 in the master cycle and in the forced cycle off the bus.
- R7: At most one bit of `master_o` is 1 in any cycle.
- R8: A lower-priority device can win while higher-priority devices are in their master cycle or their forced cycle off the bus. If the devices of bits 1 to 3 keep requesting, bit 0 is never master. Once they stop, bit 0 does become master.
- R9: If `req_i` is low at the end of the forced cycle off the bus, the controller goes idle, with `br_o` at 0, and stays idle while `req_i` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | N_DEV | Local bus request from each device (bit i is priority i+1) |
| br_o | output | N_DEV | Shared request lines as driven by the controllers |
| master_o | output | N_DEV | Device holds the bus in this cycle |
| done_o | output | N_DEV | Transaction of the device finished in the previous cycle |

## Verification
In the same cycle, one device can be completing its master cycle while another device wins arbitration. This happens because the current master does not drive its request line. The bench provokes it by having all four devices request at once and keep requesting. It then checks the exact rotation of masters, request lines and done pulses cycle by cycle, and confirms that mastership passes from one device to the next with no gap and no overlap. A monitor checks every cycle that there is never more than one master and never a repeat master.

// File: rtl/dist_arb_pkg.sv
package dist_arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_REQ     = 2'd1,
    ST_MASTER  = 2'd2,
    ST_BACKOFF = 2'd3
  } arb_state_e;
endpackage

// File: rtl/arb_prio_filter.sv
module arb_prio_filter #(
  parameter int N_DEV    = 4,
  parameter int PRIO_IDX = 0
) (
  input  logic [N_DEV-1:0] br_bus_i,
  output logic             higher_o
);
  always_comb begin
    higher_o = 1'b0;
    for (int j = 0; j < N_DEV; j++) begin
      if (j > PRIO_IDX) higher_o = higher_o | br_bus_i[j];
    end
  end
endmodule

// File: rtl/arb_node.sv
module arb_node
  import dist_arb_pkg::*;
#(
  parameter int N_DEV    = 4,
  parameter int PRIO_IDX = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [N_DEV-1:0] br_bus_i,
  output logic             br_o,
  output logic             master_o,
  output logic             done_o
);
  arb_state_e state_q, state_d;
  logic       higher_req;

  arb_prio_filter #(.N_DEV(N_DEV), .PRIO_IDX(PRIO_IDX)) u_filter (
    .br_bus_i (br_bus_i),
    .higher_o (higher_req)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (req_i) state_d = ST_REQ;
      ST_REQ:     if (!higher_req) state_d = ST_MASTER;
      ST_MASTER:  state_d = ST_BACKOFF;
      ST_BACKOFF: state_d = req_i ? ST_REQ : ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // Moore outputs
  assign br_o     = (state_q == ST_REQ);
  assign master_o = (state_q == ST_MASTER);
  assign done_o   = (state_q == ST_BACKOFF);

  // R3
  prio_yield_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_o && higher_req) |=> !master_o);

  // R4
  done_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_o |=> (done_o && !master_o));

  // R5
  no_repeat_master_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_o |=> !master_o);

  // R6
  br_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_o |=> (br_o || master_o));

  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!br_o && !master_o && !done_o && !req_i) |=> !br_o);
endmodule

// File: rtl/dist_bus_arb.sv
module dist_bus_arb #(
  parameter int N_DEV = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_DEV-1:0] req_i,
  output logic [N_DEV-1:0] br_o,
  output logic [N_DEV-1:0] master_o,
  output logic [N_DEV-1:0] done_o
);
  logic [N_DEV-1:0] br_bus;

  for (genvar g = 0; g < N_DEV; g++) begin : g_node
    arb_node #(.N_DEV(N_DEV), .PRIO_IDX(g)) u_node (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .req_i    (req_i[g]),
      .br_bus_i (br_bus),
      .br_o     (br_bus[g]),
      .master_o (master_o[g]),
      .done_o   (done_o[g])
    );
  end

  assign br_o = br_bus;

  // R7
  single_master_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(master_o));

  // R6
  master_br_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_o & br_bus) == '0);

  // R1
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |=> (br_o == '0 && master_o == '0 && done_o == '0));
endmodule

// File: tb/dist_bus_arb_bench.sv
module dist_bus_arb_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] req_i = '0;
  logic [3:0] br_o, master_o, done_o;

  int checks = 0;
  int errors = 0;
  int mon_err = 0;
  logic [3:0] prev_master = '0;

  dist_bus_arb #(.N_DEV(4)) u_dist_bus_arb (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i),
    .br_o(br_o), .master_o(master_o), .done_o(done_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // R7 and R5 monitor, sampled away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if ($countones(master_o) > 1) mon_err++;
      if ((master_o & prev_master) != '0) mon_err++;
      prev_master = master_o;
    end else prev_master = '0;
  end

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    req_i  = '0;
    @(negedge clk_i);
    chk("R1 br in reset", br_o, 4'b0000);
    chk("R1 master in reset", master_o, 4'b0000);
    rst_ni = 1'b1;
    tick();
    chk("R1 br after reset", br_o, 4'b0000);
    chk("R1 done after reset", done_o, 4'b0000);
  endtask

  task automatic t_single();
    req_i = 4'b0001;
    tick();
    chk("R2 br raised", br_o, 4'b0001);
    chk("R2 no master yet", master_o, 4'b0000);
    req_i = 4'b0000;
    tick();
    chk("R2 master granted", master_o, 4'b0001);
    chk("R6 br low in master", br_o, 4'b0000);
    tick();
    chk("R4 done pulse", done_o, 4'b0001);
    chk("R4 master one cycle", master_o, 4'b0000);
    tick();
    chk("R9 idle br", br_o, 4'b0000);
    chk("R4 done cleared", done_o, 4'b0000);
    tick();
    chk("R9 stays idle", br_o | master_o, 4'b0000);
  endtask

  task automatic t_drop_hold();
    req_i = 4'b1001;
    tick();
    chk("R3 both request", br_o, 4'b1001);
    req_i = 4'b0000;
    tick();
    chk("R3 highest wins", master_o, 4'b1000);
    chk("R6 br held after req drop", br_o, 4'b0001);
    tick();
    chk("R8 low wins during high done", master_o, 4'b0001);
    chk("R4 high done", done_o, 4'b1000);
    tick();
    tick();
    chk("R9 quiet after", br_o | master_o | done_o, 4'b0000);
  endtask

  task automatic t_rotation();
    int low_wins = 0;
    req_i = 4'b1111;
    tick();
    chk("R2 all request", br_o, 4'b1111);
    tick();
    chk("R3 m4", master_o, 4'b1000);
    chk("R3 br t2", br_o, 4'b0111);
    tick();
    chk("R8 m3", master_o, 4'b0100);
    chk("R8 br t3", br_o, 4'b0011);
    tick();
    chk("R8 m2", master_o, 4'b0010);
    chk("R5 br t4", br_o, 4'b1001);
    chk("R4 done t4", done_o, 4'b0100);
    tick();
    chk("R5 m4 again", master_o, 4'b1000);
    for (int k = 0; k < 30; k++) begin
      tick();
      if (master_o[0]) low_wins++;
    end
    chk("R8 starved", low_wins[3:0], 4'd0);
    req_i = 4'b0001;
    low_wins = 0;
    for (int k = 0; k < 8; k++) begin
      tick();
      if (master_o[0]) low_wins++;
    end
    chk("R8 low eventually wins", {3'b000, (low_wins > 0)}, 4'b0001);
    req_i = 4'b0000;
    tick(); tick(); tick(); tick();
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    t_reset();
    t_single();
    t_drop_hold();
    t_rotation();
    checks++;
    if (mon_err != 0) begin
      errors++;
      $display("FAIL R7 monitor actual=%0d expected=0", mon_err);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule